// File: doc/BRIEF.md
# Run-Length Configuration Bit Expander

This block turns a stream of compressed configuration bytes into the serial data and clock strobe needed by a slave-serial configuration port of a programmable device. Bytes arrive one at a time, in sequence, from a byte-wide read-only store over a valid/ready handshake. A last-byte flag marks the end of the image.

Each byte carries one of two kinds of content. A literal byte holds seven bits that are sent as they are. A run byte holds a bit value and a repeat count, so a long stretch of identical configuration bits costs a single byte. The expander emits one bit per slot of `STROBE_DIV` system clocks. Each bit is placed on the data line one cycle before a one-cycle strobe. Once the flagged byte has been fully sent, the block raises a sticky done flag.

Top module: `rle_cfg_expander`

## Requirements
- R1: A byte with bit 7 = 0 is a literal: its bits 6..0 are sent as seven output bits, bit 6 first and bit 0 last.
- R2: A byte with bit 7 = 1 is a run: bits 5..0 give a count N from 1 to 63, and N output bits are sent, each equal to bit 6 of the byte.
- R3: A run byte whose count field is 0 produces no strobe and is consumed; the input becomes ready for the next byte without any output activity.
- R4: Each output bit is on `cfg_data` at least one cycle before its strobe and is unchanged during the strobe cycle. `cfg_strobe` is never high for two cycles in a row.
- R5: Strobes belonging to the same input byte are exactly `STROBE_DIV` cycles apart.
- R6: `in_ready` stays low from the acceptance of a byte until the last bit of that byte has been strobed. Whenever `in_ready` is high, every bit of every accepted byte has already been strobed.
- R7: After the byte accepted with `in_last` = 1 has been fully sent, `cfg_done` rises and stays high until reset. While it is high, `in_ready` is low and no strobe occurs.
- R8: During and right after synchronous reset, `cfg_strobe` = 0, `cfg_done` = 0, `cfg_data` = 0 and `in_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| in_byte | input | 8 | Compressed byte (literal or run) |
| in_valid | input | 1 | `in_byte` and `in_last` are valid |
| in_last | input | 1 | This byte ends the image |
| in_ready | output | 1 | Block can take a byte this cycle |
| cfg_data | output | 1 | Serial configuration data bit |
| cfg_strobe | output | 1 | One-cycle configuration clock pulse |
| cfg_done | output | 1 | Whole image has been sent (sticky) |

## Verification
The assertions assume that the source holds `in_byte` and `in_last` steady while `in_valid` is high and the block is not ready. They also assume that `STROBE_DIV` is at least 2, so that a data change and a strobe never fall in the same slot cycle. The stimulus presents each byte only after a clock edge and keeps it unchanged until it sees `in_ready` high. Byte values, gaps between bytes and stream lengths are random; directed streams add zero-length runs, the longest run and an image that consists of a single empty run. After done, `in_valid` is held high with random bytes to show that nothing further is taken or sent.

// File: rtl/rle_cfg_pkg.sv
package rle_cfg_pkg;
  localparam int BYTE_W = 8;
  localparam int LIT_W  = 7;
  localparam int CNT_W  = 6;

  // high bit set means the byte describes a run
  function automatic logic is_run(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1];
  endfunction

  // number of output bits that a byte expands into
  function automatic logic [CNT_W-1:0] bit_total(input logic [BYTE_W-1:0] b);
    if (is_run(b)) return b[CNT_W-1:0];
    return CNT_W'(LIT_W);
  endfunction

  // repeated value of a run byte
  function automatic logic run_value(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-2];
  endfunction
endpackage

// File: rtl/rle_slot_timer.sv
module rle_slot_timer #(
  parameter int DIV = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic slot_end,
  output logic strobe
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST_PH = PW'(DIV - 1);

  logic [PW-1:0] phase;
  logic          strobe_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      phase <= '0;
    end else if (phase == LAST_PH) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  // the strobe lands one cycle after the slot opens with the new bit
  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= run && (phase == '0);
  end

  assign slot_end = run && (phase == LAST_PH);
  assign strobe   = strobe_q;

  // R5
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    phase <= LAST_PH);
endmodule

// File: rtl/rle_bit_source.sv
module rle_bit_source
  import rle_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              advance,
  output logic              cur_bit,
  output logic              last_bit
);
  logic [LIT_W-1:0] shreg;
  logic             run_mode;
  logic             run_val;
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg    <= '0;
      run_mode <= 1'b0;
      run_val  <= 1'b0;
      count    <= '0;
    end else if (load) begin
      shreg    <= load_byte[LIT_W-1:0];
      run_mode <= is_run(load_byte);
      run_val  <= run_value(load_byte);
      count    <= bit_total(load_byte);
    end else if (advance) begin
      shreg    <= {shreg[LIT_W-2:0], 1'b0};
      count    <= count - 1'b1;
    end
  end

  assign cur_bit  = run_mode ? run_val : shreg[LIT_W-1];
  assign last_bit = (count == CNT_W'(1));

  // R1 R2: in both formats the first bit sent is bit 6 of the byte
  first_bit_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> cur_bit == $past(load_byte[BYTE_W-2]));

  // R6
  count_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    advance |-> count != '0);
endmodule

// File: rtl/rle_cfg_expander.sv
module rle_cfg_expander
  import rle_cfg_pkg::*;
#(
  parameter int STROBE_DIV = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  output logic              cfg_data,
  output logic              cfg_strobe,
  output logic              cfg_done
);
  logic busy;
  logic last_q;
  logic done_q;
  logic accept;
  logic nonempty;
  logic slot_end;
  logic last_bit;
  logic byte_finish;
  logic advance;
  logic cur_bit;

  assign in_ready    = !busy && !done_q;
  assign accept      = in_valid && in_ready;
  assign nonempty    = (bit_total(in_byte) != '0);
  assign byte_finish = slot_end && last_bit;
  assign advance     = slot_end && !last_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      last_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (accept) last_q <= in_last;
      if (accept && nonempty) busy <= 1'b1;
      else if (byte_finish)   busy <= 1'b0;
      if ((accept && !nonempty && in_last) || (byte_finish && last_q))
        done_q <= 1'b1;
    end
  end

  rle_slot_timer #(.DIV(STROBE_DIV)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .run      (busy),
    .slot_end (slot_end),
    .strobe   (cfg_strobe)
  );

  rle_bit_source u_src (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .load_byte (in_byte),
    .advance   (advance),
    .cur_bit   (cur_bit),
    .last_bit  (last_bit)
  );

  assign cfg_data = cur_bit;
  assign cfg_done = done_q;

  // R4
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_strobe |=> !cfg_strobe);

  // R4
  data_setup_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_strobe |-> $stable(cfg_data));

  // R6
  ready_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_strobe |-> !in_ready);

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_done |=> cfg_done);

  // R7
  done_silent_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_done |-> (!cfg_strobe && !in_ready));
endmodule

// File: tb/test_rle_cfg_expander.sv
module test_rle_cfg_expander;
  localparam int DIV = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] in_byte = '0;
  logic       in_valid = 1'b0;
  logic       in_last = 1'b0;
  logic       in_ready, cfg_data, cfg_strobe, cfg_done;

  int tests = 0, fails = 0;
  longint cyc = 0;

  logic   got_q[$];
  logic   exp_q[$];
  string  tag_q[$];
  logic [7:0] stim[$];
  int     acc_bits = 0;
  logic   prev_data = 1'b0, prev_strobe = 1'b0;
  longint last_strobe = -1;
  bit     new_byte = 1'b1;

  always #4 clk = ~clk;

  rle_cfg_expander #(.STROBE_DIV(DIV)) i_rle_cfg_expander (
    .clk(clk), .rst(rst), .in_byte(in_byte), .in_valid(in_valid),
    .in_last(in_last), .in_ready(in_ready), .cfg_data(cfg_data),
    .cfg_strobe(cfg_strobe), .cfg_done(cfg_done));

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic int tb_len(input logic [7:0] b);
    return b[7] ? int'(b[5:0]) : 7;
  endfunction

  function automatic logic tb_bit(input logic [7:0] b, input int i);
    return b[7] ? b[6] : b[6 - i];
  endfunction

  // output monitor, sampling away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (cfg_strobe) begin
        check(cfg_data == prev_data, "R4 data held before strobe", cfg_data, prev_data);
        check(!prev_strobe, "R4 strobe single cycle", prev_strobe, 0);
        check(!in_ready, "R6 ready low while sending", in_ready, 0);
        if (!new_byte && last_strobe >= 0)
          check(cyc - last_strobe == DIV, "R5 strobe spacing", cyc - last_strobe, DIV);
        last_strobe = cyc;
        new_byte = 1'b0;
        got_q.push_back(cfg_data);
      end
      if (in_ready)
        check(got_q.size() == acc_bits, "R6 all bits out when ready", got_q.size(), acc_bits);
      if (in_valid && in_ready) begin
        acc_bits += tb_len(in_byte);
        new_byte = 1'b1;
      end
    end
    prev_data = cfg_data;
    prev_strobe = cfg_strobe;
  end

  // watchdog
  initial begin
    wait (cyc > 150000);
    check(1'b0, "watchdog expired", cyc, 150000);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(cfg_strobe == 0, "R8 strobe in reset", cfg_strobe, 0);
    check(cfg_done == 0, "R8 done in reset", cfg_done, 0);
    check(cfg_data == 0, "R8 data in reset", cfg_data, 0);
    check(in_ready == 1, "R8 ready in reset", in_ready, 1);
    got_q.delete(); exp_q.delete(); tag_q.delete();
    acc_bits = 0; new_byte = 1'b1; last_strobe = -1;
    @(posedge clk); #1 rst = 1'b0;
  endtask

  task automatic play_stream();
    foreach (stim[k]) begin
      for (int i = 0; i < tb_len(stim[k]); i++) begin
        exp_q.push_back(tb_bit(stim[k], i));
        tag_q.push_back(stim[k][7] ? "R2 run bit" : "R1 literal bit");
      end
    end
    foreach (stim[k]) begin
      repeat ($urandom % 3) @(posedge clk);
      #1;
      in_byte = stim[k];
      in_last = (k == stim.size() - 1);
      in_valid = 1'b1;
      forever begin
        @(negedge clk);
        if (in_ready) break;
      end
      @(posedge clk); #1 in_valid = 1'b0;
    end
    for (int w = 0; w < 3000 && !cfg_done; w++) @(negedge clk);
    check(cfg_done == 1, "R7 done after last byte", cfg_done, 1);
    check(got_q.size() == exp_q.size(), "R1 R2 R3 bit count", got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      if (got_q[i] !== exp_q[i]) check(1'b0, tag_q[i], got_q[i], exp_q[i]);
      else tests++;
    // R7: further bytes offered after done are not taken and send nothing
    @(posedge clk); #1;
    in_valid = 1'b1; in_byte = 8'hFF; in_last = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(!in_ready && !cfg_strobe, "R7 quiet after done", {in_ready, cfg_strobe}, 0);
      check(cfg_done, "R7 done sticky", cfg_done, 1);
      #1 in_byte = 8'($urandom);
    end
    check(got_q.size() == exp_q.size(), "R7 no extra bits", got_q.size(), exp_q.size());
    in_valid = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240617));
    // directed: literal pattern and maximal run
    do_reset();
    stim = '{8'h55, 8'h2A, 8'hFF, 8'h81};
    play_stream();
    // R3: zero-length runs inside a stream and as the last byte
    do_reset();
    stim = '{8'h80, 8'h7F, 8'hC0, 8'h00, 8'h80};
    play_stream();
    // R3: image made only of one empty run
    do_reset();
    stim = '{8'hC0};
    play_stream();
    check(got_q.size() == 0, "R3 empty run sends nothing", got_q.size(), 0);
    // random streams
    for (int s = 0; s < 12; s++) begin
      do_reset();
      stim.delete();
      for (int n = 0; n < 4 + ($urandom % 20); n++) begin
        logic [7:0] b;
        b = 8'($urandom);
        if ($urandom % 5 == 0) b[5:0] = ($urandom % 2) ? 6'd0 : 6'd63;
        stim.push_back(b);
      end
      play_stream();
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule